// File: doc/BRIEF.md
# Sign-Magnitude H-Bridge PWM Driver

This block turns a signed duty command into the three control lines of one DC motor H-bridge leg pair. Two of the lines are direction lines: drive A is high for forward, drive B is high for reverse, and both are low to let the motor coast. The third line is a pulse-width-modulated enable whose high time within each PWM period follows the command's magnitude. Each motor gets its own instance of the block.

The command is a signed two's-complement word. Its magnitude is clamped to a full-scale value of `2**FS_LOG2`. The clamped magnitude is scaled to a number of high cycles per period: `on = (|cmd| * PERIOD) >> FS_LOG2`, where `PERIOD = CLK_HZ / PWM_HZ`. With the default 125 MHz clock and a 20 kHz rate, the period is 6250 cycles, or 50 µs. A free-running counter marks the period boundary. The command is captured only at that boundary, so the direction lines and the enable never change shape in the middle of a period.

Top module: `hbridge_pwm`

## Requirements
- R1: From reset, drive A, drive B and enable are all low, and they stay low through the first PWM period.
- R2: A positive command gives drive A = 1 and drive B = 0. The enable is high for `(min(|cmd|, 2**FS_LOG2) * PERIOD) >> FS_LOG2` cycles of the period. This count can be 0 for very small commands.
- R3: A negative command gives drive A = 0 and drive B = 1. The enable high count follows the same formula as R2, using the command's magnitude.
- R4: A zero command gives the coast state: both drive lines are low and the enable stays low for the whole period.
- R5: A command whose magnitude is 2**FS_LOG2 or more is treated as full scale. The enable is then high for all `PERIOD` cycles, and the direction still follows the sign.
- R6: The most negative code (the sign bit alone) has the same magnitude as full-scale positive: reverse direction with the enable high for the whole period.
- R7: The period is `CLK_HZ / PWM_HZ` clock cycles. Within each period the enable is high as one contiguous run that starts at the period's first cycle.
- R8: The command is sampled only at the period boundary, which is the clock edge ending the period's last cycle. A change during a period does not alter that period. The value present at the boundary governs the next period.
- R9: Drive A and drive B are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_i | input | DUTY_W | Signed duty command, two's complement |
| drive_a_o | output | 1 | Forward direction line |
| drive_b_o | output | 1 | Reverse direction line |
| enable_o | output | 1 | PWM enable line |

## Verification
The bench builds the block with DUTY_W = 16 and FS_LOG2 = 14, so full scale is 16384. It uses CLK_HZ = 125 MHz and PWM_HZ = 1.25 MHz, which gives a 100-cycle period. The short period lets one run cover many whole periods, each scored cycle by cycle. The 16-bit word has codes above full scale and below its negative, so clamping in both directions, the most negative code and a command just under full scale (99 of 100 cycles) can all be reached. Commands of 100 and 164 land on high counts of 0 and 1 at the small end of the scaling.

// File: rtl/hbp_pkg.sv
// Package: shared types for the H-bridge PWM driver.
// Assumes: direction code bit 0 drives line A and bit 1 drives line B.
package hbp_pkg;

    // Direction state; the code is decoded bit by bit onto the drive lines.
    typedef enum logic [1:0] {
        DIR_COAST = 2'b00,
        DIR_FWD   = 2'b01,
        DIR_REV   = 2'b10
    } hbp_dir_e;

endpackage

// File: rtl/hbp_cmd_shaper.sv
// Module: hbp_cmd_shaper
// Turns a signed duty command into a direction code and a count of
// enable-high cycles per period. Purely combinational.
// Assumes: FS_LOG2 <= DUTY_W-2, so full scale fits the positive range,
// and PERIOD >= 2.
module hbp_cmd_shaper
    import hbp_pkg::*;
#(
    parameter int DUTY_W  = 16,
    parameter int FS_LOG2 = 14,
    parameter int PERIOD  = 6250,
    parameter int CNT_W   = 13
) (
    input  logic signed [DUTY_W-1:0] duty_i,
    output hbp_dir_e                 dir_o,
    output logic [CNT_W:0]           on_o
);

    localparam int MAG_W  = FS_LOG2 + 1;
    localparam int PROD_W = MAG_W + CNT_W + 1;
    localparam logic [DUTY_W:0]   FULL_WIDE = (DUTY_W+1)'(1) << FS_LOG2;
    localparam logic [PROD_W-1:0] PERIOD_P  = PROD_W'(PERIOD);

    logic [DUTY_W:0]   mag_raw;
    logic [MAG_W-1:0]  mag;
    logic [PROD_W-1:0] prod;

    // Absolute value, one bit wider so the most negative code cannot overflow.
    always_comb begin
        if (duty_i[DUTY_W-1])
            mag_raw = {1'b0, ~duty_i} + (DUTY_W+1)'(1);
        else
            mag_raw = {1'b0, duty_i};
    end

    // Clamp the magnitude to full scale.
    always_comb begin
        if (mag_raw >= FULL_WIDE)
            mag = MAG_W'(FULL_WIDE);
        else
            mag = mag_raw[MAG_W-1:0];
    end

    // Direction from sign and zero test.
    always_comb begin
        if (mag_raw == '0)
            dir_o = DIR_COAST;
        else if (duty_i[DUTY_W-1])
            dir_o = DIR_REV;
        else
            dir_o = DIR_FWD;
    end

    // Scale the magnitude to period cycles; full scale is a power of two.
    always_comb begin
        prod = PROD_W'(mag) * PERIOD_P;
        on_o = prod[FS_LOG2 +: CNT_W+1];
    end

endmodule

// File: rtl/hbp_period_ctr.sv
// Module: hbp_period_ctr
// Free-running period counter: counts 0..PERIOD-1 and flags the last count.
// Assumes: PERIOD >= 2 and CNT_W = $clog2(PERIOD).
module hbp_period_ctr #(
    parameter int PERIOD = 6250,
    parameter int CNT_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Next count and end-of-period flag.
    always_comb begin
        wrap_o    = (cnt_q == LAST);
        cnt_nxt_o = wrap_o ? '0 : cnt_q + CNT_W'(1);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt_o;
    end

    assign cnt_o = cnt_q;

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < PERIOD);

    // R7
    wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/hbp_out_stage.sv
// Module: hbp_out_stage
// Holds the command captured at the period boundary and drives registered
// direction and enable lines from it.
// Assumes: cnt_nxt_i/wrap_i come from hbp_period_ctr in the same clock domain.
module hbp_out_stage
    import hbp_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  hbp_dir_e         dir_i,
    input  logic [CNT_W:0]   on_i,
    output logic             drive_a_o,
    output logic             drive_b_o,
    output logic             enable_o
);

    hbp_dir_e       dir_q;
    logic [CNT_W:0] on_q;
    hbp_dir_e       dir_eff;
    logic [CNT_W:0] on_eff;

    // Values in force for the coming cycle: new ones only at the boundary.
    always_comb begin
        dir_eff = wrap_i ? dir_i : dir_q;
        on_eff  = wrap_i ? on_i  : on_q;
    end

    // Shadow registers for the captured command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_COAST;
            on_q  <= '0;
        end else begin
            dir_q <= dir_eff;
            on_q  <= on_eff;
        end
    end

    // Registered output lines, glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_a_o <= 1'b0;
            drive_b_o <= 1'b0;
            enable_o  <= 1'b0;
        end else begin
            drive_a_o <= dir_eff[0];
            drive_b_o <= dir_eff[1];
            enable_o  <= ({1'b0, cnt_nxt_i} < on_eff);
        end
    end

    // R9
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_a_o && drive_b_o));

    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap_i) |-> ($stable(drive_a_o) && $stable(drive_b_o)));

    // R4
    coast_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o |-> (drive_a_o || drive_b_o));

    // R7
    enable_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap_i) |-> (enable_o == (on_q != '0)));

endmodule

// File: rtl/hbridge_pwm.sv
// Module: hbridge_pwm (top)
// Sign-magnitude H-bridge PWM driver for one motor: signed duty in,
// two direction lines and one PWM enable out.
// Assumes: CLK_HZ / PWM_HZ >= 2; FS_LOG2 <= DUTY_W-2.
module hbridge_pwm
    import hbp_pkg::*;
#(
    parameter int DUTY_W  = 16,
    parameter int FS_LOG2 = 14,
    parameter int CLK_HZ  = 125_000_000,
    parameter int PWM_HZ  = 20_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DUTY_W-1:0] duty_i,
    output logic                     drive_a_o,
    output logic                     drive_b_o,
    output logic                     enable_o
);

    localparam int PERIOD = CLK_HZ / PWM_HZ;
    localparam int CNT_W  = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    hbp_dir_e         dir_cmd;
    logic [CNT_W:0]   on_cmd;

    hbp_cmd_shaper #(
        .DUTY_W (DUTY_W),
        .FS_LOG2(FS_LOG2),
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_shaper (
        .duty_i(duty_i),
        .dir_o (dir_cmd),
        .on_o  (on_cmd)
    );

    hbp_period_ctr #(
        .PERIOD(PERIOD),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_o    (cnt),
        .cnt_nxt_o(cnt_nxt),
        .wrap_o   (wrap)
    );

    hbp_out_stage #(
        .CNT_W(CNT_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (wrap),
        .cnt_nxt_i(cnt_nxt),
        .dir_i    (dir_cmd),
        .on_i     (on_cmd),
        .drive_a_o(drive_a_o),
        .drive_b_o(drive_b_o),
        .enable_o (enable_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!drive_a_o && !drive_b_o && !enable_o));

    // R5
    full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(on_cmd) <= PERIOD) && (32'(cnt) < PERIOD));

endmodule

// File: tb/hbridge_pwm_bench.sv
// Scoreboard bench: driver pushes per-period expectations, monitor measures
// each period at the outputs and compares.
module hbridge_pwm_bench;

    localparam int DW  = 16;
    localparam int FSL = 14;
    localparam int P   = 100;
    localparam int FS  = 1 << FSL;

    typedef struct {
        int    win;
        bit    a;
        bit    b;
        int    on;
        string req;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] duty = '0;
    logic                 drv_a, drv_b, en;

    int   total = 0;
    int   bad = 0;
    int   e = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    hbridge_pwm #(
        .DUTY_W(DW), .FS_LOG2(FSL), .CLK_HZ(125_000_000), .PWM_HZ(1_250_000)
    ) u_hbridge_pwm (
        .clk(clk), .rst_n(rst_n), .duty_i(duty),
        .drive_a_o(drv_a), .drive_b_o(drv_b), .enable_o(en)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) e <= e + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic exp_t mk(input int d, input int win, input string req);
        exp_t x;
        int   m = (d < 0) ? -d : d;
        if (m > FS) m = FS;
        x.win = win;
        x.a   = (d > 0);
        x.b   = (d < 0);
        x.on  = (m * P) / FS;
        x.req = req;
        return x;
    endfunction

    // Wait for the start of a window (negedge after a boundary edge).
    task automatic to_window_start(output int w);
        do @(negedge clk); while (!(e > 0 && (e % P) == 0));
        w = e / P;
    endtask

    task automatic cmd(input int d, input string req);
        int w;
        to_window_start(w);
        duty = DW'(d);
        q.push_back(mk(d, w + 1, req));
    endtask

    // Change mid-period: only the second value should reach the next period.
    task automatic cmd_mid(input int d1, input int d2, input string req);
        int w;
        to_window_start(w);
        duty = DW'(d1);
        do @(negedge clk); while ((e % P) != P / 2);
        duty = DW'(d2);
        q.push_back(mk(d2, w + 1, req));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: measures each window and scores it against the queue head.
    int mw_hi, mw_first, mw_last;
    bit mw_a, mw_b, mw_stable;
    always @(negedge clk) begin
        if (rst_n && e >= P) begin
            int pos;
            pos = e % P;
            if (pos == 0) begin
                mw_a = drv_a; mw_b = drv_b; mw_stable = 1'b1;
                mw_hi = 0; mw_first = -1; mw_last = -1;
            end
            if (drv_a !== mw_a || drv_b !== mw_b) mw_stable = 1'b0;
            if (en === 1'b1) begin
                mw_hi++;
                if (mw_first < 0) mw_first = pos;
                mw_last = pos;
            end
            if (pos == P - 1 && q.size() > 0 && q[0].win == e / P) begin
                exp_t x;
                x = q.pop_front();
                chk(mw_a == x.a, x.req, "drive_a", mw_a, x.a);
                chk(mw_b == x.b, x.req, "drive_b", mw_b, x.b);
                chk(mw_hi == x.on, x.req, "enable high cycles", mw_hi, x.on);
                // R8: direction constant through the period
                chk(mw_stable, "R8", "direction stable in period", mw_stable, 1);
                // R9: never both lines high
                chk(!(mw_a && mw_b), "R9", "both drive lines", mw_a & mw_b, 0);
                if (x.on > 0) begin
                    // R7: run starts at cycle 0 and is contiguous
                    chk(mw_first == 0, "R7", "enable start cycle", mw_first, 0);
                    chk(mw_last - mw_first + 1 == mw_hi, "R7", "enable run length",
                        mw_last - mw_first + 1, mw_hi);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    // Driver
    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs low while in reset
        chk(drv_a == 0, "R1", "drive_a in reset", drv_a, 0);
        chk(drv_b == 0, "R1", "drive_b in reset", drv_b, 0);
        chk(en == 0, "R1", "enable in reset", en, 0);
        q.push_back(mk(0, 1, "R1"));
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(en == 0 && drv_a == 0 && drv_b == 0, "R1", "first period quiet",
            {drv_a, drv_b, en}, 0);

        cmd(8192, "R2");
        cmd(-4096, "R3");
        cmd(0, "R4");
        cmd(16384, "R5");
        cmd(30000, "R5");
        cmd(-20000, "R5");
        cmd(-32768, "R6");
        cmd(32767, "R6");
        cmd(100, "R2");
        cmd(164, "R2");
        cmd(-16383, "R3");
        cmd(0, "R4");
        cmd_mid(4096, -12288, "R8");
        cmd_mid(0, 12288, "R8");
        cmd(0, "R4");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule